// File: doc/BRIEF.md
# Load/Store Lane Aligner

This block sits between the memory stage of a load/store pipeline and a memory bus that has a 64-bit read path and a separate 64-bit write path. It takes one request per clock, with a 32-bit address and an access size of byte, halfword, word or doubleword. A request that is not naturally aligned for its size is rejected with an error pulse. An aligned request goes out on the bus with a doubleword-aligned address and one enable per byte lane. For stores, the low bytes of the operand are moved into the addressed lanes. For loads, the addressed lanes are pulled out of the read data and returned as a register value.

Each request can ask for its bytes to be reversed. Sub-word load results can be zero-extended or sign-extended. On loads, reversal is applied to the extracted bytes before extension, so the sign of a reversed halfword comes from the byte that was at the lower address. Byte, halfword and word loads produce a 32-bit value in the low half of the result, with the upper half zero unless it is filled by sign extension of a byte or halfword. A doubleword load returns all 64 bits.

Requests flow through with no stall. The bus side is fixed-latency: read data for a bus request is valid in the same cycle as that request. The load result appears one cycle after the bus request.

Top module: `ldst_aligner`

## Requirements
- R1: While reset is asserted, busReqValid, alignErr and ldValid are all 0.
- R2: An aligned request sampled at a clock edge is on the bus after that edge: busReqValid=1, busAddr equals the request address with its low 3 bits cleared, and busWrite equals reqIsStore.
- R3: reqSize encodes 0=byte, 1=halfword, 2=word, 3=doubleword (N = 1, 2, 4 or 8 bytes). busByteEn bit k drives byte lane k (data bits 8k+7:8k). The lanes enabled are lane addr[2:0] up to lane addr[2:0]+N-1, for loads and stores alike. busByteEn is 0 when there is no bus request.
- R4: Without reversal, store byte i of reqWrData (bits 8i+7:8i, i<N) appears on lane addr[2:0]+i of busWrData. Operand bytes at or above N are ignored, and every disabled lane is 0.
- R5: With reqByteRev=1, the N store bytes are placed in reversed order: operand byte N-1-i goes to lane addr[2:0]+i.
- R6: A load takes lanes addr[2:0] to addr[2:0]+N-1 of busRdData as result bytes 0..N-1. With reqSignExt=0, all bits above the loaded bytes are 0. A word load has its upper 32 bits at 0 regardless of reqSignExt.
- R7: With reqSignExt=1, a byte load fills bits 63:8 with bit 7 of the result, and a halfword load fills bits 63:16 with bit 15 of the result.
- R8: With reqByteRev=1, the N extracted load bytes are reversed before extension, so the sign bit is taken from the reversed value.
- R9: A doubleword load (N=8) returns all 64 bits of busRdData, reversed when reqByteRev=1, and reqSignExt has no effect on it.
- R10: A request whose address low bits are not a multiple of N produces alignErr=1 for one cycle after the sampling edge. It produces no bus request and no load result.
- R11: A new request is accepted every clock. Each aligned load yields ldValid=1 with ldData exactly one cycle after its bus request, so back-to-back loads return one result per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | Access size code |
| reqAddr | input | 32 | Byte address |
| reqSignExt | input | 1 | Sign-extend byte/halfword loads |
| reqByteRev | input | 1 | Reverse byte order of the access |
| reqWrData | input | 64 | Store operand, right-justified |
| busReqValid | output | 1 | Bus request |
| busWrite | output | 1 | Bus request is a write |
| busAddr | output | 32 | Doubleword-aligned bus address |
| busByteEn | output | 8 | Per-lane byte enables |
| busWrData | output | 64 | Write data in lanes |
| busRdData | input | 64 | Read data, valid with the bus request |
| alignErr | output | 1 | Misaligned request rejected |
| ldValid | output | 1 | Load result valid |
| ldData | output | 64 | Aligned, reversed and extended load result |

## Verification
Bus request, address, byte enables, write data and the alignment error are registered once, so they are due in the cycle after the request is sampled. The load result passes through a second register, so it is due one cycle after its bus request, which is two cycles after the request. The bench sweeps every size, lane offset, sign and reversal setting for loads and stores, issuing one request per clock. It keeps a two-deep record of past requests and checks the bus outputs against the request from one cycle back, and the load outputs against the request from two cycles back. All checks are sampled at the falling edge, when the outputs are settled.

// File: rtl/ldst_pkg.sv
package ldst_pkg;

  localparam int BUS_BYTES = 8;
  localparam int BUS_W     = 8 * BUS_BYTES;
  localparam int LANE_W    = $clog2(BUS_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  // strobes and qualifiers from control to datapath
  typedef struct packed {
    logic              storeCapture;
    accSize_e          storeSize;
    logic [LANE_W-1:0] storeLane;
    logic              storeRev;
    logic              loadCapture;
    accSize_e          loadSize;
    logic [LANE_W-1:0] loadLane;
    logic              loadSign;
    logic              loadRev;
  } dpCtrl_t;

  function automatic int bytesOf(input accSize_e sz);
    return 1 << int'(sz);
  endfunction

  function automatic logic [BUS_W-1:0] byteMask(input int nBytes);
    logic [BUS_W-1:0] m;
    m = '0;
    for (int i = 0; i < BUS_BYTES; i++)
      if (i < nBytes) m[8*i +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [BUS_W-1:0] reverseLanes(input logic [BUS_W-1:0] d,
                                                    input int nBytes);
    logic [BUS_W-1:0] r;
    r = '0;
    for (int i = 0; i < BUS_BYTES; i++)
      if (i < nBytes) r[8*i +: 8] = d[8*(nBytes-1-i) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/ldst_ctrl.sv
module ldst_ctrl
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsStore,
  input  accSize_e             reqSize,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqSignExt,
  input  logic                 reqByteRev,
  output logic                 busReqValid,
  output logic                 busWrite,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [BUS_BYTES-1:0] busByteEn,
  output logic                 alignErr,
  output logic                 ldValid,
  output dpCtrl_t              dpCtrl
);

  logic [LANE_W:0]        accBytes;
  logic [LANE_W:0]        accMask;
  logic [LANE_W-1:0]      lane;
  logic                   misaligned;
  logic                   issue;
  logic [BUS_BYTES-1:0]   beNext;

  accSize_e               s1Size;
  logic [LANE_W-1:0]      s1Lane;
  logic                   s1Sign;
  logic                   s1Rev;

  assign lane       = reqAddr[LANE_W-1:0];
  assign accBytes   = (LANE_W+1)'(1) << reqSize;
  assign accMask    = accBytes - 1'b1;
  assign misaligned = |(lane & accMask[LANE_W-1:0]);
  assign issue      = reqValid && !misaligned;

  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_laneEn
    assign beNext[k] = issue && (k >= int'(lane)) && (k < int'(lane) + int'(accBytes));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busReqValid <= 1'b0;
      busWrite    <= 1'b0;
      busAddr     <= '0;
      busByteEn   <= '0;
      alignErr    <= 1'b0;
      ldValid     <= 1'b0;
      s1Size      <= SZ_BYTE;
      s1Lane      <= '0;
      s1Sign      <= 1'b0;
      s1Rev       <= 1'b0;
    end else begin
      busReqValid <= issue;
      busWrite    <= issue && reqIsStore;
      busAddr     <= {reqAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
      busByteEn   <= beNext;
      alignErr    <= reqValid && misaligned;
      ldValid     <= busReqValid && !busWrite;
      s1Size      <= reqSize;
      s1Lane      <= lane;
      s1Sign      <= reqSignExt;
      s1Rev       <= reqByteRev;
    end
  end

  always_comb begin
    dpCtrl.storeCapture = issue && reqIsStore;
    dpCtrl.storeSize    = reqSize;
    dpCtrl.storeLane    = lane;
    dpCtrl.storeRev     = reqByteRev;
    dpCtrl.loadCapture  = busReqValid && !busWrite;
    dpCtrl.loadSize     = s1Size;
    dpCtrl.loadLane     = s1Lane;
    dpCtrl.loadSign     = s1Sign;
    dpCtrl.loadRev      = s1Rev;
  end

  // R10: a rejected access never turns into a load result
  assert_err_no_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    alignErr |=> !ldValid);

  // R11: each load bus request is followed by a result on the next cycle
  assert_load_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && !busWrite) |=> ldValid);

  assert_load_origin_R11: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |-> $past(busReqValid && !busWrite));

  // R3: enables form a power-of-two lane group, none when idle
  assert_be_group_R3: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid |-> ($countones(busByteEn) == 1 || $countones(busByteEn) == 2 ||
                     $countones(busByteEn) == 4 || $countones(busByteEn) == 8));

  assert_be_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    !busReqValid |-> (busByteEn == '0));

endmodule

// File: rtl/ldst_datapath.sv
module ldst_datapath
  import ldst_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtrl_t              dpCtrl,
  input  logic [BUS_W-1:0]     reqWrData,
  input  logic [BUS_W-1:0]     busRdData,
  input  logic                 busReqValid,
  input  logic                 busWrite,
  input  logic [BUS_BYTES-1:0] busByteEn,
  output logic [BUS_W-1:0]     busWrData,
  output logic [BUS_W-1:0]     ldData
);

  localparam int HALF_W = BUS_W / 2;

  logic [BUS_W-1:0] stPacked, stOrdered, stPlaced;
  logic [BUS_W-1:0] ldShift, ldRaw, ldOrdered, ldExt;
  int               stBytes, ldBytes;

  // store side: trim operand, optionally reverse, move into lanes
  always_comb begin
    stBytes   = bytesOf(dpCtrl.storeSize);
    stPacked  = reqWrData & byteMask(stBytes);
    stOrdered = dpCtrl.storeRev ? reverseLanes(stPacked, stBytes) : stPacked;
    stPlaced  = stOrdered << {dpCtrl.storeLane, 3'b000};
  end

  // load side: pull lanes down, optionally reverse, then extend
  always_comb begin
    ldBytes   = bytesOf(dpCtrl.loadSize);
    ldShift   = busRdData >> {dpCtrl.loadLane, 3'b000};
    ldRaw     = ldShift & byteMask(ldBytes);
    ldOrdered = dpCtrl.loadRev ? reverseLanes(ldRaw, ldBytes) : ldRaw;
    unique case (dpCtrl.loadSize)
      SZ_BYTE:  ldExt = {{(BUS_W-8){dpCtrl.loadSign & ldOrdered[7]}}, ldOrdered[7:0]};
      SZ_HALF:  ldExt = {{(BUS_W-16){dpCtrl.loadSign & ldOrdered[15]}}, ldOrdered[15:0]};
      SZ_WORD:  ldExt = {{(BUS_W-HALF_W){1'b0}}, ldOrdered[HALF_W-1:0]};
      default:  ldExt = ldOrdered;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busWrData <= '0;
      ldData    <= '0;
    end else begin
      busWrData <= dpCtrl.storeCapture ? stPlaced : '0;
      if (dpCtrl.loadCapture) ldData <= ldExt;
    end
  end

  logic [BUS_W-1:0] enBits;
  for (genvar k = 0; k < BUS_BYTES; k++) begin : g_enBits
    assign enBits[8*k +: 8] = {8{busByteEn[k]}};
  end

  // R4: write data is confined to the enabled lanes
  assert_wr_in_lanes_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busReqValid && busWrite) |-> ((busWrData & ~enBits) == '0));

  // R2: write data only moves with a write request
  assert_wr_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(busReqValid && busWrite) |-> (busWrData == '0));

endmodule

// File: rtl/ldst_aligner.sv
module ldst_aligner
  import ldst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqIsStore,
  input  logic [1:0]           reqSize,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqSignExt,
  input  logic                 reqByteRev,
  input  logic [BUS_W-1:0]     reqWrData,
  output logic                 busReqValid,
  output logic                 busWrite,
  output logic [ADDR_W-1:0]    busAddr,
  output logic [BUS_BYTES-1:0] busByteEn,
  output logic [BUS_W-1:0]     busWrData,
  input  logic [BUS_W-1:0]     busRdData,
  output logic                 alignErr,
  output logic                 ldValid,
  output logic [BUS_W-1:0]     ldData
);

  dpCtrl_t dpCtrl;

  ldst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqIsStore  (reqIsStore),
    .reqSize     (accSize_e'(reqSize)),
    .reqAddr     (reqAddr),
    .reqSignExt  (reqSignExt),
    .reqByteRev  (reqByteRev),
    .busReqValid (busReqValid),
    .busWrite    (busWrite),
    .busAddr     (busAddr),
    .busByteEn   (busByteEn),
    .alignErr    (alignErr),
    .ldValid     (ldValid),
    .dpCtrl      (dpCtrl)
  );

  ldst_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .dpCtrl      (dpCtrl),
    .reqWrData   (reqWrData),
    .busRdData   (busRdData),
    .busReqValid (busReqValid),
    .busWrite    (busWrite),
    .busByteEn   (busByteEn),
    .busWrData   (busWrData),
    .ldData      (ldData)
  );

endmodule

// File: tb/ldst_aligner_tb.sv
module ldst_aligner_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid, reqIsStore, reqSignExt, reqByteRev;
  logic [1:0]  reqSize;
  logic [31:0] reqAddr;
  logic [63:0] reqWrData;
  logic        busReqValid, busWrite, alignErr, ldValid;
  logic [31:0] busAddr;
  logic [7:0]  busByteEn;
  logic [63:0] busWrData, busRdData, ldData;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ldst_aligner u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqSize(reqSize), .reqAddr(reqAddr), .reqSignExt(reqSignExt),
    .reqByteRev(reqByteRev), .reqWrData(reqWrData), .busReqValid(busReqValid),
    .busWrite(busWrite), .busAddr(busAddr), .busByteEn(busByteEn),
    .busWrData(busWrData), .busRdData(busRdData), .alignErr(alignErr),
    .ldValid(ldValid), .ldData(ldData)
  );

  function automatic logic [63:0] memWord(input logic [31:0] a);
    return {a ^ 32'h8C4F_F1B7, (a * 32'h9E37_79B9) ^ 32'h7F80_80FF};
  endfunction

  assign busRdData = memWord(busAddr);

  function automatic logic [63:0] nMask(input int n);
    return (n == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << (8 * n)) - 64'd1);
  endfunction

  function automatic logic [63:0] revN(input logic [63:0] d, input int n);
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) r[8*i +: 8] = d[8*(n-1-i) +: 8];
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // pipeline record: p1 = previous request, p2 = the one before
  bit          p1V = 0, p1S, p1Sg, p1Rv, p2V = 0, p2S, p2Sg, p2Rv;
  int          p1Sz, p2Sz;
  logic [31:0] p1A, p2A;
  logic [63:0] p1D, p2D;

  task automatic checkStages();
    int  n, off;
    bit  ok;
    logic [63:0] e, raw;
    // bus stage, request from one cycle back
    n = 1 << p1Sz; off = int'(p1A[2:0]);
    ok = p1V && (off % n == 0);
    check("R10 alignErr", 64'(alignErr), 64'(p1V && !ok));
    check("R2 busReqValid", 64'(busReqValid), 64'(ok));
    if (ok) begin
      check("R2 busAddr", 64'(busAddr), 64'({p1A[31:3], 3'b000}));
      check("R2 busWrite", 64'(busWrite), 64'(p1S));
      check("R3 busByteEn", 64'(busByteEn), 64'(8'(((16'd1 << n) - 16'd1) << off)));
      if (p1S) begin
        e = p1D & nMask(n);
        if (p1Rv) e = revN(e, n);
        e = e << (8 * off);
        check(p1Rv ? "R5 busWrData" : "R4 busWrData", busWrData, e);
      end
    end else begin
      check("R3 busByteEn idle", 64'(busByteEn), 64'd0);
    end
    // load stage, request from two cycles back
    n = 1 << p2Sz; off = int'(p2A[2:0]);
    ok = p2V && !p2S && (off % n == 0);
    check("R11 ldValid", 64'(ldValid), 64'(ok));
    if (ok) begin
      raw = (memWord({p2A[31:3], 3'b000}) >> (8 * off)) & nMask(n);
      if (p2Rv) raw = revN(raw, n);
      if (p2Sg && n == 1 && raw[7])  raw = raw | ~nMask(1);
      if (p2Sg && n == 2 && raw[15]) raw = raw | ~nMask(2);
      if (n == 8)        check("R9 ldData", ldData, raw);
      else if (p2Rv)     check("R8 ldData", ldData, raw);
      else if (p2Sg)     check("R7 ldData", ldData, raw);
      else               check("R6 ldData", ldData, raw);
    end
  endtask

  task automatic stepCycle(input bit v, input bit st, input int sz, input logic [31:0] a,
                           input bit sg, input bit rv, input logic [63:0] d);
    @(negedge clk);
    checkStages();
    reqValid = v; reqIsStore = st; reqSize = 2'(sz); reqAddr = a;
    reqSignExt = sg; reqByteRev = rv; reqWrData = d;
    p2V = p1V; p2S = p1S; p2Sz = p1Sz; p2A = p1A; p2Sg = p1Sg; p2Rv = p1Rv; p2D = p1D;
    p1V = v;   p1S = st;  p1Sz = sz;   p1A = a;   p1Sg = sg;   p1Rv = rv;   p1D = d;
  endtask

  initial begin
    int iter = 0;
    rstN = 1'b0; reqValid = 0; reqIsStore = 0; reqSize = 0; reqAddr = 0;
    reqSignExt = 0; reqByteRev = 0; reqWrData = 0;
    p1Sz = 0; p2Sz = 0; p1A = 0; p2A = 0; p1D = 0; p2D = 0;
    p1S = 0; p2S = 0; p1Sg = 0; p2Sg = 0; p1Rv = 0; p2Rv = 0;
    repeat (3) @(negedge clk);
    check("R1 busReqValid", 64'(busReqValid), 64'd0);
    check("R1 alignErr", 64'(alignErr), 64'd0);
    check("R1 ldValid", 64'(ldValid), 64'd0);
    rstN = 1'b1;
    for (int base = 0; base < 2; base++)
      for (int st = 0; st < 2; st++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 8; off++)
            for (int sg = 0; sg < 2; sg++)
              for (int rv = 0; rv < 2; rv++) begin
                logic [31:0] a;
                logic [63:0] d;
                iter++;
                a = (base == 0 ? 32'h0000_1000 : 32'hFFFF_E000) + 32'(iter << 3) + 32'(off);
                d = {32'(iter) * 32'hA5A5_3C3C, ~(32'(iter) * 32'h0F1E_2D4B)};
                stepCycle(1'b1, st[0], sz, a, sg[0], rv[0], d);
                if (iter % 37 == 0) stepCycle(1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b0, 64'h0);
              end
    repeat (3) stepCycle(1'b0, 1'b0, 0, 32'h0, 1'b0, 1'b0, 64'h0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule